// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block holds the software-visible configuration and status of a simple LCD controller. A processor reaches it through a single-cycle register port of six word-aligned locations: control, three timing words, status and subpanel. The unit stores the configuration fields and drives them to the rest of the controller. It keeps the geometry as a stored field plus one and forces fixed one-bits into several readbacks. Three status flags are set by strobes from the frame sequencer and are combined into one interrupt line.

Turning the controller on or off is the only control event with side effects. It counts only when a control write changes the stored enable bit. On such a change the unit raises a one-cycle pulse for the frame sequencer and updates the status flags. A sync error from the sequencer switches the controller off without a pulse. A sync error also holds the interrupt up no matter how the mask is set. Pixel timing generation and the display datapath are outside this unit.

Top module: `lcd_reg_bank`

## Requirements
- R1: After reset every field and flag is zero. The reads then return control 0xFE000C34, timing0 0x0000000F, timing1 0, timing2 0xFC000000, status 0 and subpanel 0. irq, enable_pulse and bad_access are low.
- R2: A write to offset 0x00 stores the panel mode from bits 21:20, TFT from bit 7, the interrupt mask from bits 4:3, mono from bit 1 and enable from bit 0. It also keeps the bits under mask 0x01CFF300. The control read ORs these fields back into the same positions, with TFT also at bit 23, and then ORs in 0xFE000C34.
- R3: Offsets 0x04 and 0x08 store bits 9:0 as a geometry field and bits 31:10 as a separate timing field. line_width and frame_height present the geometry field plus one. The read of 0x04 ORs in 0x0000000F; the read of 0x08 returns the stored value unchanged.
- R4: Offset 0x0C stores all 32 bits and reads back with 0xFC000000 ORed in.
- R5: Offset 0x14 stores the written word ANDed with 0xA1FFFFFF and reads that back.
- R6: The read of offset 0x10 gives palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0, with all other bits zero. Writes to 0x10 change nothing.
- R7: irq is high exactly when frame-done is set with mask bit 0 (control bit 3), or palette-done is set with mask bit 1 (control bit 4), or sync-error is set. The mask does not affect sync-error. irq follows the flags in the same cycle.
- R8: A control write whose bit 0 differs from the stored enable makes enable_pulse high for exactly the next cycle. A write that leaves the bit unchanged gives no pulse.
- R9: When a write turns enable on, frame-done and palette-done clear. When a write turns enable off, sync-error clears, and frame-done sets unless the written panel mode is 1. A set strobe in the same cycle takes precedence over these clears.
- R10: A sync_err_set strobe sets sync-error and forces the stored enable to 0 on that edge. This takes precedence over a simultaneous control write, and it raises no enable_pulse.
- R11: A read or write at an offset other than the six above is unmapped. A read there returns 0, a write there changes nothing, and bad_access goes high for the one cycle after the access.
- R12: rdata is loaded on the edge that samples rd_en, and it holds its value while rd_en is low. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| bad_access | output | 1 | One-cycle strobe after an unmapped access |
| frame_done_set | input | 1 | Sequencer strobe that sets frame-done |
| palette_done_set | input | 1 | Sequencer strobe that sets palette-done |
| sync_err_set | input | 1 | Sequencer strobe that sets sync-error and drops enable |
| irq | output | 1 | Combined interrupt |
| enable_pulse | output | 1 | One-cycle pulse when enable changes by write |
| lcd_enable | output | 1 | Stored enable bit |
| panel_mode | output | 2 | Stored panel-load mode |
| tft_mode | output | 1 | Stored TFT flag |
| mono_mode | output | 1 | Stored mono flag |
| line_width | output | 11 | Width field plus one |
| frame_height | output | 11 | Height field plus one |
| h_timing | output | 22 | Upper field of timing0 |
| v_timing | output | 22 | Upper field of timing1 |
| timing2_cfg | output | 32 | Stored timing2 word |
| subpanel_cfg | output | 32 | Stored subpanel word |

## Verification
The hardest situations to reach are the collisions on the enable bit. One is a sync error in the same cycle as a control write that turns enable on. Others are a disable with panel mode 1, and a set strobe that meets the clear caused by an enable edge. Random stimulus alone reaches these only rarely. The stimulus therefore weights writes to the control offset and toggles bit 0 often. It issues sequencer strobes with a modest probability, so that they regularly fall in the same cycle as enable edges. Directed sequences then force each collision at least once.

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;
   localparam int unsigned NUM_REGS = 6;

   localparam logic [31:0] CTRL_KEEP_MASK = 32'h01CF_F300;
   localparam logic [31:0] CTRL_RD_ONES   = 32'hFE00_0C34;
   localparam logic [31:0] T0_RD_ONES     = 32'h0000_000F;
   localparam logic [31:0] T2_RD_ONES     = 32'hFC00_0000;
   localparam logic [31:0] SUB_WR_MASK    = 32'hA1FF_FFFF;

   // index of each register; offset is index * 4
   typedef enum logic [2:0] {
      RI_CTRL = 3'd0,
      RI_T0   = 3'd1,
      RI_T1   = 3'd2,
      RI_T2   = 3'd3,
      RI_STAT = 3'd4,
      RI_SUB  = 3'd5
   } reg_idx_e;

   // panel mode value for which disabling does not flag frame completion
   localparam logic [1:0] PMODE_NO_FRAME = 2'd1;

   typedef struct packed {
      logic [1:0] pmode;
      logic       tft;
      logic [1:0] imask;
      logic       mono;
      logic       en;
   } ctrl_fields_t;
endpackage

// File: rtl/lcd_reg_decode.sv
module lcd_reg_decode #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NUM_REGS = 6
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] sel,
   output logic                hit
);
   localparam int unsigned IDX_W = $clog2(NUM_REGS);

   if (ADDR_W < IDX_W + 2) begin : g_chk_addr
      $error("lcd_reg_decode: ADDR_W too small for register count");
   end

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_sel
      localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(gi * 4);
      assign sel[gi] = (addr == OFFS);
   end

   assign hit = |sel;
endmodule

// File: rtl/lcd_reg_cfg.sv
module lcd_reg_cfg
   import lcd_reg_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned GEO_W  = 10,
   localparam int unsigned HI_W  = DATA_W - GEO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_t0,
   input  logic              wr_t1,
   input  logic              wr_t2,
   input  logic              wr_sub,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sync_err_set,
   output ctrl_fields_t      ctrl_q,
   output logic [DATA_W-1:0] ctrl_keep_q,
   output logic [GEO_W-1:0]  width_fld,
   output logic [GEO_W-1:0]  height_fld,
   output logic [HI_W-1:0]   t0_hi,
   output logic [HI_W-1:0]   t1_hi,
   output logic [DATA_W-1:0] t2_q,
   output logic [DATA_W-1:0] sub_q,
   output logic              en_on,
   output logic              en_off,
   output logic              en_pulse_q
);
   logic en_chg;
   logic en_next;

   assign en_chg = wr_ctrl && (wdata[0] != ctrl_q.en);
   assign en_on  = en_chg && wdata[0];
   assign en_off = en_chg && !wdata[0];

   always_comb begin
      en_next = wr_ctrl ? wdata[0] : ctrl_q.en;
      if (sync_err_set) en_next = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         ctrl_keep_q <= '0;
         en_pulse_q  <= 1'b0;
      end else begin
         en_pulse_q <= en_chg;
         ctrl_q.en  <= en_next;
         if (wr_ctrl) begin
            ctrl_q.pmode <= wdata[21:20];
            ctrl_q.tft   <= wdata[7];
            ctrl_q.imask <= wdata[4:3];
            ctrl_q.mono  <= wdata[1];
            ctrl_keep_q  <= wdata & CTRL_KEEP_MASK[DATA_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         width_fld  <= '0;
         height_fld <= '0;
         t0_hi      <= '0;
         t1_hi      <= '0;
         t2_q       <= '0;
         sub_q      <= '0;
      end else begin
         if (wr_t0) begin
            width_fld <= wdata[GEO_W-1:0];
            t0_hi     <= wdata[DATA_W-1:GEO_W];
         end
         if (wr_t1) begin
            height_fld <= wdata[GEO_W-1:0];
            t1_hi      <= wdata[DATA_W-1:GEO_W];
         end
         if (wr_t2)  t2_q  <= wdata;
         if (wr_sub) sub_q <= wdata & SUB_WR_MASK[DATA_W-1:0];
      end
   end
endmodule

// File: rtl/lcd_reg_status.sv
module lcd_reg_status
   import lcd_reg_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_on,
   input  logic       en_off,
   input  logic [1:0] pmode_new,
   input  logic [1:0] imask,
   input  logic       frame_done_set,
   input  logic       palette_done_set,
   input  logic       sync_err_set,
   output logic       frame_done,
   output logic       palette_done,
   output logic       sync_err,
   output logic       irq
);
   logic fd_n, pd_n, se_n;
   logic irq_c;

   always_comb begin
      fd_n = frame_done;
      pd_n = palette_done;
      se_n = sync_err;
      if (en_on) begin
         fd_n = 1'b0;
         pd_n = 1'b0;
      end
      if (en_off) begin
         se_n = 1'b0;
         if (pmode_new != PMODE_NO_FRAME) fd_n = 1'b1;
      end
      if (frame_done_set)   fd_n = 1'b1;
      if (palette_done_set) pd_n = 1'b1;
      if (sync_err_set)     se_n = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_done   <= 1'b0;
         palette_done <= 1'b0;
         sync_err     <= 1'b0;
      end else begin
         frame_done   <= fd_n;
         palette_done <= pd_n;
         sync_err     <= se_n;
      end
   end

   assign irq_c = (frame_done && imask[0]) || (palette_done && imask[1]) || sync_err;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_c;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_c;
   end
endmodule

// File: rtl/lcd_reg_bank.sv
module lcd_reg_bank
   import lcd_reg_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned GEO_W   = 10,
   parameter bit          IRQ_REG = 1'b0,
   localparam int unsigned HI_W   = DATA_W - GEO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              bad_access,
   input  logic              frame_done_set,
   input  logic              palette_done_set,
   input  logic              sync_err_set,
   output logic              irq,
   output logic              enable_pulse,
   output logic              lcd_enable,
   output logic [1:0]        panel_mode,
   output logic              tft_mode,
   output logic              mono_mode,
   output logic [GEO_W:0]    line_width,
   output logic [GEO_W:0]    frame_height,
   output logic [HI_W-1:0]   h_timing,
   output logic [HI_W-1:0]   v_timing,
   output logic [DATA_W-1:0] timing2_cfg,
   output logic [DATA_W-1:0] subpanel_cfg
);
   if (DATA_W != 32) begin : g_chk_data
      $error("lcd_reg_bank: DATA_W must be 32");
   end
   if (GEO_W < 4 || GEO_W > 20) begin : g_chk_geo
      $error("lcd_reg_bank: GEO_W out of range");
   end

   logic [NUM_REGS-1:0] sel;
   logic                hit;
   ctrl_fields_t        ctrl_q;
   logic [DATA_W-1:0]   ctrl_keep_q;
   logic [GEO_W-1:0]    width_fld, height_fld;
   logic                en_on, en_off;
   logic                st_frame, st_pal, st_sync;
   logic [DATA_W-1:0]   rd_vec [NUM_REGS];
   logic [DATA_W-1:0]   rd_mux;
   logic                bad_q;

   lcd_reg_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
      .addr (addr),
      .sel  (sel),
      .hit  (hit)
   );

   lcd_reg_cfg #(.DATA_W(DATA_W), .GEO_W(GEO_W)) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_ctrl      (wr_en && sel[RI_CTRL]),
      .wr_t0        (wr_en && sel[RI_T0]),
      .wr_t1        (wr_en && sel[RI_T1]),
      .wr_t2        (wr_en && sel[RI_T2]),
      .wr_sub       (wr_en && sel[RI_SUB]),
      .wdata        (wdata),
      .sync_err_set (sync_err_set),
      .ctrl_q       (ctrl_q),
      .ctrl_keep_q  (ctrl_keep_q),
      .width_fld    (width_fld),
      .height_fld   (height_fld),
      .t0_hi        (h_timing),
      .t1_hi        (v_timing),
      .t2_q         (timing2_cfg),
      .sub_q        (subpanel_cfg),
      .en_on        (en_on),
      .en_off       (en_off),
      .en_pulse_q   (enable_pulse)
   );

   lcd_reg_status #(.IRQ_REG(IRQ_REG)) u_stat (
      .clk              (clk),
      .rst_n            (rst_n),
      .en_on            (en_on),
      .en_off           (en_off),
      .pmode_new        (wdata[21:20]),
      .imask            (ctrl_q.imask),
      .frame_done_set   (frame_done_set),
      .palette_done_set (palette_done_set),
      .sync_err_set     (sync_err_set),
      .frame_done       (st_frame),
      .palette_done     (st_pal),
      .sync_err         (st_sync),
      .irq              (irq)
   );

   always_comb begin
      rd_vec[RI_CTRL] = ctrl_keep_q | CTRL_RD_ONES[DATA_W-1:0];
      rd_vec[RI_CTRL][23]    = rd_vec[RI_CTRL][23] | ctrl_q.tft;
      rd_vec[RI_CTRL][21:20] = rd_vec[RI_CTRL][21:20] | ctrl_q.pmode;
      rd_vec[RI_CTRL][7]     = rd_vec[RI_CTRL][7] | ctrl_q.tft;
      rd_vec[RI_CTRL][4:3]   = rd_vec[RI_CTRL][4:3] | ctrl_q.imask;
      rd_vec[RI_CTRL][1]     = rd_vec[RI_CTRL][1] | ctrl_q.mono;
      rd_vec[RI_CTRL][0]     = rd_vec[RI_CTRL][0] | ctrl_q.en;
      rd_vec[RI_T0]   = {h_timing, width_fld} | T0_RD_ONES[DATA_W-1:0];
      rd_vec[RI_T1]   = {v_timing, height_fld};
      rd_vec[RI_T2]   = timing2_cfg | T2_RD_ONES[DATA_W-1:0];
      rd_vec[RI_STAT] = '0;
      rd_vec[RI_STAT][6] = st_pal;
      rd_vec[RI_STAT][2] = st_sync;
      rd_vec[RI_STAT][0] = st_frame;
      rd_vec[RI_SUB]  = subpanel_cfg;
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (sel[i]) rd_mux = rd_mux | rd_vec[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         bad_q <= 1'b0;
      end else begin
         if (rd_en) rdata <= rd_mux;
         bad_q <= (wr_en || rd_en) && !hit;
      end
   end

   assign bad_access   = bad_q;
   assign lcd_enable   = ctrl_q.en;
   assign panel_mode   = ctrl_q.pmode;
   assign tft_mode     = ctrl_q.tft;
   assign mono_mode    = ctrl_q.mono;
   assign line_width   = {1'b0, width_fld} + 1'b1;
   assign frame_height = {1'b0, height_fld} + 1'b1;
endmodule

// File: rtl/lcd_reg_bank_checker.sv
module lcd_reg_bank_checker #(
   parameter int unsigned ADDR_W  = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic              bad_access,
   input logic              enable_pulse,
   input logic              lcd_enable,
   input logic              irq,
   input logic              sync_err_set,
   input logic              frame_done_set,
   input logic              st_frame,
   input logic              st_sync
);
   // R8: a pulse only follows a control write
   a_r8_pulse_after_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      enable_pulse |-> $past(wr_en && addr == '0));

   // R10: a sync error strobe leaves enable low
   a_r10_sync_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err_set |=> !lcd_enable);

   // R7: sync error cannot be masked
   a_r7_sync_forces_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && st_sync) |-> irq);

   // R11: bad access strobe only after an access
   a_r11_bad_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |-> $past(wr_en || rd_en));

   // R9: turning on clears frame-done unless a set strobe coincided
   a_r9_on_clears_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_pulse && lcd_enable && !$past(frame_done_set)) |-> !st_frame);
endmodule

bind lcd_reg_bank lcd_reg_bank_checker #(.ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .rd_en          (rd_en),
   .addr           (addr),
   .bad_access     (bad_access),
   .enable_pulse   (enable_pulse),
   .lcd_enable     (lcd_enable),
   .irq            (irq),
   .sync_err_set   (sync_err_set),
   .frame_done_set (frame_done_set),
   .st_frame       (st_frame),
   .st_sync        (st_sync)
);

// File: tb/lcd_reg_bank_bench.sv
`timescale 1ns/1ps
module lcd_reg_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, rd_en;
   logic [7:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        bad_access, irq, enable_pulse, lcd_enable;
   logic        fd_set, pd_set, se_set;
   logic [1:0]  panel_mode;
   logic        tft_mode, mono_mode;
   logic [10:0] line_width, frame_height;
   logic [21:0] h_timing, v_timing;
   logic [31:0] timing2_cfg, subpanel_cfg;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lcd_reg_bank u_lcd_reg_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .bad_access(bad_access),
      .frame_done_set(fd_set), .palette_done_set(pd_set), .sync_err_set(se_set),
      .irq(irq), .enable_pulse(enable_pulse), .lcd_enable(lcd_enable),
      .panel_mode(panel_mode), .tft_mode(tft_mode), .mono_mode(mono_mode),
      .line_width(line_width), .frame_height(frame_height),
      .h_timing(h_timing), .v_timing(v_timing),
      .timing2_cfg(timing2_cfg), .subpanel_cfg(subpanel_cfg)
   );

   // model state
   logic [1:0]  m_pm, m_mask;
   logic        m_tft, m_mono, m_en, m_fd, m_pd, m_se;
   logic [31:0] m_keep, m_t0, m_t1, m_t2, m_sub, m_rd;
   logic        m_pulse, m_bad;

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      logic [31:0] v;
      case (a)
         8'h00: v = 32'(m_tft) << 23 | 32'(m_pm) << 20 | 32'(m_tft) << 7 |
                    32'(m_mask) << 3 | 32'(m_mono) << 1 | 32'(m_en) | m_keep | 32'hFE000C34;
         8'h04: v = m_t0 | 32'hF;
         8'h08: v = m_t1;
         8'h0C: v = m_t2 | 32'hFC000000;
         8'h10: v = 32'(m_pd) << 6 | 32'(m_se) << 2 | 32'(m_fd);
         8'h14: v = m_sub;
         default: v = 32'h0;
      endcase
      return v;
   endfunction

   function automatic logic exp_irq();
      return (m_fd & m_mask[0]) | (m_pd & m_mask[1]) | m_se;
   endfunction

   function automatic string rd_tag(input logic [7:0] a);
      case (a)
         8'h00: return "R2";
         8'h04, 8'h08: return "R3";
         8'h0C: return "R4";
         8'h10: return "R6/R9";
         8'h14: return "R5";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_pm = 0; m_mask = 0; m_tft = 0; m_mono = 0; m_en = 0;
      m_fd = 0; m_pd = 0; m_se = 0; m_keep = 0; m_t0 = 0; m_t1 = 0;
      m_t2 = 0; m_sub = 0; m_rd = 0; m_pulse = 0; m_bad = 0;
   endtask

   task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                       input logic [31:0] d, input logic fs, input logic ps, input logic ss);
      logic chg;
      logic mapped;
      wr_en = wr; rd_en = rd; addr = a; wdata = d;
      fd_set = fs; pd_set = ps; se_set = ss;
      @(posedge clk);
      mapped = (a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0C || a == 8'h10 || a == 8'h14);
      if (rd) m_rd = exp_read(a);
      m_bad = (wr || rd) && !mapped;
      chg = wr && a == 8'h00 && d[0] != m_en;
      m_pulse = chg;
      if (chg && d[0]) begin m_fd = 0; m_pd = 0; end
      if (chg && !d[0]) begin m_se = 0; if (d[21:20] != 2'd1) m_fd = 1; end
      if (fs) m_fd = 1;
      if (ps) m_pd = 1;
      if (ss) m_se = 1;
      if (wr) begin
         case (a)
            8'h00: begin
               m_pm = d[21:20]; m_tft = d[7]; m_mask = d[4:3]; m_mono = d[1];
               m_en = d[0]; m_keep = d & 32'h01CFF300;
            end
            8'h04: m_t0 = d;
            8'h08: m_t1 = d;
            8'h0C: m_t2 = d;
            8'h14: m_sub = d & 32'hA1FFFFFF;
            default: ;
         endcase
      end
      if (ss) m_en = 0;
      #1;
      if (rd) check(rd_tag(a), rdata, m_rd);
      else    check("R12 hold", rdata, m_rd);
      check("R11 bad_access", 32'(bad_access), 32'(m_bad));
      check("R8 enable_pulse", 32'(enable_pulse), 32'(m_pulse));
      check("R7 irq", 32'(irq), 32'(exp_irq()));
      check("R10 lcd_enable", 32'(lcd_enable), 32'(m_en));
      check("R3 line_width", 32'(line_width), 32'(m_t0[9:0]) + 1);
      check("R3 frame_height", 32'(frame_height), 32'(m_t1[9:0]) + 1);
      wr_en = 0; rd_en = 0; fd_set = 0; pd_set = 0; se_set = 0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      step(1, 0, a, d, 0, 0, 0);
   endtask
   task automatic rd(input logic [7:0] a);
      step(0, 1, a, 32'h0, 0, 0, 0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] offs [7];
      offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18};
      void'($urandom(32'h1CD5EED));
      rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
      fd_set = 0; pd_set = 0; se_set = 0;
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset readbacks
      check("R1 irq", 32'(irq), 0);
      check("R1 pulse", 32'(enable_pulse), 0);
      for (int i = 0; i < 6; i++) begin
         step(0, 1, offs[i], 0, 0, 0, 0);
         check("R1 reset read", rdata, exp_read(offs[i]));
      end
      // R2 control fields
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00);
      wr(8'h00, 32'h0000_0000); rd(8'h00); rd(8'h10);
      // R3 R4 R5
      wr(8'h04, 32'hFFFF_FFFF); rd(8'h04);
      wr(8'h08, 32'h1234_5000); rd(8'h08);
      wr(8'h0C, 32'h0123_4567); rd(8'h0C);
      wr(8'h14, 32'hFFFF_FFFF); rd(8'h14);
      // R6 status write ignored
      step(0, 0, 0, 0, 1, 1, 0);
      wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);
      // R8 same enable twice
      wr(8'h00, 32'h1); wr(8'h00, 32'h1); rd(8'h10);
      // R9 disable with mode 1: no frame done
      wr(8'h00, 32'h0010_0000); rd(8'h10);
      // R10 sync collides with enabling write; irq with zero mask (R7)
      step(1, 0, 8'h00, 32'h1, 0, 0, 1); rd(8'h10); rd(8'h00);
      // R9 set strobe meets enable-on clear
      step(1, 0, 8'h00, 32'h19, 1, 0, 0); rd(8'h10);
      // R12 read and write same cycle
      step(1, 1, 8'h0C, 32'hFFFF_0000, 0, 0, 0); rd(8'h0C);
      // R11 unmapped and unaligned
      step(1, 1, 8'h02, 32'hFFFF_FFFF, 0, 0, 0); step(0, 1, 8'h80, 0, 0, 0, 0);
      for (int i = 0; i < 1500; i++) begin
         logic [7:0] a;
         logic [31:0] d;
         int r;
         r = $urandom_range(0, 9);
         if (r < 4) a = 8'h00;
         else if (r < 9) a = offs[$urandom_range(0, 5)];
         else a = 8'($urandom);
         d = $urandom;
         if ($urandom_range(0, 3) == 0) d[21:20] = 2'd1;
         step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a, d,
              $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
              $urandom_range(0, 15) == 0);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule